// File: doc/BRIEF.md
# Data-Link Message Receiver for DS3 Path Maintenance

This block recovers bit-oriented data-link messages from the serial maintenance channel of a DS3 stream. The upstream framer picks out the three data-link bits in the fifth F-frame of every M-frame. It presents each of those bits on `bit_in` with a one-cycle `bit_vld` strobe, so bits arrive in short bursts with idle gaps between them. The receiver finds the `0x7E` flag delimiters and drops the zero that the sender inserts after five ones. It packs the data bits into bytes, least significant bit first, and verifies the 16-bit frame check sequence.

The information bytes of each message go into a fixed window of the on-chip message RAM, from byte address `0xDE` up to `0x135`. They are written through a plain write port (enable, address, data). Every message starts again at the bottom of the window. When the closing flag arrives, the block pulses an end-of-message strobe. Alongside that strobe it presents the message length, a check-sequence error bit and an overflow bit. These status outputs keep their values until the next message completes.

Top module: `lapd_pmdl_rx`

## Requirements
- R1: A flag byte (`0x7E`, the bit pattern 0 1 1 1 1 1 1 0) opens and closes a message, and one flag may close one message and open the next. A flag that follows another flag with no complete byte between them produces no end-of-message.
- R2: Between flags, a 0 that follows five consecutive 1 data bits is discarded and is never part of a stored byte.
- R3: Data bits are packed into bytes with the first received bit in bit 0. The information bytes of a message are written in order to consecutive addresses starting at `0xDE`, with one write strobe per byte.
- R4: The last two bytes before the closing flag are the check sequence. They are never written, and `msg_len` reports the number of information bytes. `msg_len`, `fcs_err` and `ovfl` change only in the cycle that `eom` is high.
- R5: The check sequence is CRC-16 with polynomial x^16+x^12+x^5+1. It is processed bit-reflected, preset to 0xFFFF, and sent as the complement of the register, low byte first. `fcs_err` is 0 when the running CRC over all bytes including the check sequence equals 0xF0B8, and 1 otherwise.
- R6: Each closing flag that ends a message of at least one complete byte gives exactly one `eom` pulse, one cycle wide.
- R7: Seven consecutive 1 bits abort the open message. No `eom` is given for it, and reception resumes at the next flag.
- R8: No write ever targets an address above `0x135`. Bytes that do not fit are dropped, `ovfl` is 1 for that message with `msg_len` still giving the full count, and `ovfl` returns to 0 for the next message that fits.
- R9: A message whose bit count between flags is not a multiple of eight, or that has fewer than two bytes, ends with `fcs_err` = 1.
- R10: `bit_in` is ignored while `bit_vld` is low.
- R11: After reset, `buf_we`, `eom`, `fcs_err`, `ovfl` and `msg_len` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Strobe marking one valid data-link bit on `bit_in` |
| bit_in | input | 1 | Serial data-link bit |
| buf_we | output | 1 | Message RAM write enable |
| buf_addr | output | ADDR_W (9) | Message RAM byte address |
| buf_wdata | output | 8 | Information byte to store |
| eom | output | 1 | End-of-message pulse |
| fcs_err | output | 1 | Check-sequence or framing error of the last message |
| ovfl | output | 1 | Last message did not fit the window |
| msg_len | output | LEN_W (10) | Information byte count of the last message |

## Verification
The assertions take for granted that the strobe carries the only meaning on the serial input. Every write and every end-of-message must trace back to a strobed bit exactly three registers earlier. A complete byte needs eight strobed bits and a flag needs a full byte-length pattern, so writes and end-of-message pulses can never fall in adjacent cycles. The stimulus keeps to these assumptions because it sends bits in groups of three strobes followed by two unstrobed cycles, the way the framer delivers them. During those gaps it deliberately holds `bit_in` high, which would look like an abort if the strobe were ignored.

// File: rtl/lapd_rx_pkg.sv
package lapd_rx_pkg;

   localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
   localparam logic [15:0] CRC_GOOD     = 16'hF0B8;
   localparam logic [15:0] CRC_POLY_REF = 16'h8408;
   localparam int          FCS_BYTES    = 2;

   // one event per strobed line bit, produced by the flag/destuff stage
   typedef struct packed {
      logic dat_vld;
      logic dat_bit;
      logic flag;
      logic abort;
   } line_ev_t;

   function automatic logic [15:0] crc_step_byte(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REF;
         else             r = r >> 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/lapd_flag_destuff.sv
module lapd_flag_destuff
   import lapd_rx_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     bit_vld,
   input  logic     bit_in,
   output line_ev_t ev
);

   logic [2:0] ones_run;   // saturates at 7

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ev       <= '0;
         ones_run <= '0;
      end else begin
         ev <= '0;
         if (bit_vld) begin
            if (bit_in) begin
               if (ones_run != 3'd7) ones_run <= ones_run + 3'd1;
               if (ones_run == 3'd6) begin
                  ev.abort <= 1'b1;
               end else if (ones_run < 3'd6) begin
                  ev.dat_vld <= 1'b1;
                  ev.dat_bit <= 1'b1;
               end
            end else begin
               ones_run <= '0;
               if (ones_run == 3'd6) begin
                  ev.flag <= 1'b1;
               end else if (ones_run != 3'd5) begin
                  ev.dat_vld <= 1'b1;
                  ev.dat_bit <= 1'b0;
               end
            end
         end
      end
   end

endmodule

// File: rtl/lapd_byte_packer.sv
module lapd_byte_packer
   import lapd_rx_pkg::*;
#(
   parameter int LEN_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  line_ev_t         ev,
   output logic             info_vld,
   output logic [7:0]       info_byte,
   output logic             frm_start,
   output logic             frm_end,
   output logic             frm_bad,
   output logic [LEN_W-1:0] frm_len
);

   localparam logic [LEN_W-1:0] FCS_N   = LEN_W'(FCS_BYTES);
   localparam logic [LEN_W-1:0] CNT_MAX = '1;

   logic             in_frame;
   logic [2:0]       bit_cnt;
   logic [7:0]       shreg;
   logic [LEN_W-1:0] byte_cnt;
   logic [15:0]      crc;
   logic [7:0]       new_byte;
   logic             byte_done;
   logic [7:0]       hold [FCS_BYTES];

   assign new_byte  = {ev.dat_bit, shreg[7:1]};
   assign byte_done = ev.dat_vld && in_frame && !ev.abort && !ev.flag && (bit_cnt == 3'd7);

   // delay line that keeps the trailing check-sequence bytes back from the buffer
   for (genvar g = 0; g < FCS_BYTES; g++) begin : g_hold
      always_ff @(posedge clk) begin
         if (!rst_n)         hold[g] <= '0;
         else if (byte_done) hold[g] <= (g == 0) ? new_byte : hold[(g == 0) ? 0 : g-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame  <= 1'b0;
         bit_cnt   <= '0;
         shreg     <= '0;
         byte_cnt  <= '0;
         crc       <= CRC_PRESET;
         info_vld  <= 1'b0;
         info_byte <= '0;
         frm_start <= 1'b0;
         frm_end   <= 1'b0;
         frm_bad   <= 1'b0;
         frm_len   <= '0;
      end else begin
         info_vld  <= 1'b0;
         frm_start <= 1'b0;
         frm_end   <= 1'b0;
         if (ev.abort) begin
            in_frame <= 1'b0;
         end else if (ev.flag) begin
            if (in_frame && byte_cnt != '0) begin
               frm_end <= 1'b1;
               frm_bad <= (bit_cnt != 3'd7) || (byte_cnt < FCS_N) || (crc != CRC_GOOD);
               frm_len <= (byte_cnt >= FCS_N) ? byte_cnt - FCS_N : '0;
            end
            frm_start <= 1'b1;
            in_frame  <= 1'b1;
            bit_cnt   <= '0;
            byte_cnt  <= '0;
            crc       <= CRC_PRESET;
         end else if (ev.dat_vld && in_frame) begin
            shreg   <= new_byte;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
               crc <= crc_step_byte(crc, new_byte);
               if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + 1'b1;
               if (byte_cnt >= FCS_N) begin
                  info_vld  <= 1'b1;
                  info_byte <= hold[FCS_BYTES-1];
               end
            end
         end
      end
   end

endmodule

// File: rtl/lapd_buf_writer.sv
module lapd_buf_writer #(
   parameter int BUF_BASE = 'hDE,
   parameter int BUF_LAST = 'h135,
   parameter int ADDR_W   = 9,
   parameter int LEN_W    = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              info_vld,
   input  logic [7:0]        info_byte,
   input  logic              frm_start,
   input  logic              frm_end,
   input  logic              frm_bad,
   input  logic [LEN_W-1:0]  frm_len,
   output logic              buf_we,
   output logic [ADDR_W-1:0] buf_addr,
   output logic [7:0]        buf_wdata,
   output logic              eom,
   output logic              fcs_err,
   output logic              ovfl,
   output logic [LEN_W-1:0]  msg_len
);

   localparam int                DEPTH   = BUF_LAST - BUF_BASE + 1;
   localparam int                CW      = $clog2(DEPTH + 1);
   localparam logic [CW-1:0]     DEPTH_C = CW'(DEPTH);
   localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BUF_BASE);

   logic [CW-1:0] wr_cnt;
   logic          ovfl_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_cnt    <= '0;
         ovfl_r    <= 1'b0;
         buf_we    <= 1'b0;
         buf_addr  <= '0;
         buf_wdata <= '0;
         eom       <= 1'b0;
         fcs_err   <= 1'b0;
         ovfl      <= 1'b0;
         msg_len   <= '0;
      end else begin
         buf_we <= 1'b0;
         eom    <= 1'b0;
         if (frm_end) begin
            eom     <= 1'b1;
            fcs_err <= frm_bad;
            ovfl    <= ovfl_r;
            msg_len <= frm_len;
         end
         if (frm_start) begin
            wr_cnt <= '0;
            ovfl_r <= 1'b0;
         end else if (info_vld) begin
            if (wr_cnt < DEPTH_C) begin
               buf_we    <= 1'b1;
               buf_addr  <= BASE_A + ADDR_W'(wr_cnt);
               buf_wdata <= info_byte;
               wr_cnt    <= wr_cnt + 1'b1;
            end else begin
               ovfl_r <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/lapd_pmdl_rx.sv
module lapd_pmdl_rx
   import lapd_rx_pkg::*;
#(
   parameter int BUF_BASE = 'hDE,
   parameter int BUF_LAST = 'h135,
   parameter int ADDR_W   = 9,
   parameter int LEN_W    = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_vld,
   input  logic              bit_in,
   output logic              buf_we,
   output logic [ADDR_W-1:0] buf_addr,
   output logic [7:0]        buf_wdata,
   output logic              eom,
   output logic              fcs_err,
   output logic              ovfl,
   output logic [LEN_W-1:0]  msg_len
);

   if (BUF_LAST < BUF_BASE || BUF_LAST >= (1 << ADDR_W) || LEN_W < 2) begin : g_bad_cfg
      $error("lapd_pmdl_rx: buffer window or length width out of range");
   end

   line_ev_t         ev;
   logic             info_vld;
   logic [7:0]       info_byte;
   logic             frm_start;
   logic             frm_end;
   logic             frm_bad;
   logic [LEN_W-1:0] frm_len;

   lapd_flag_destuff i_destuff (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_vld (bit_vld),
      .bit_in  (bit_in),
      .ev      (ev)
   );

   lapd_byte_packer #(.LEN_W(LEN_W)) i_packer (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (ev),
      .info_vld  (info_vld),
      .info_byte (info_byte),
      .frm_start (frm_start),
      .frm_end   (frm_end),
      .frm_bad   (frm_bad),
      .frm_len   (frm_len)
   );

   lapd_buf_writer #(
      .BUF_BASE (BUF_BASE),
      .BUF_LAST (BUF_LAST),
      .ADDR_W   (ADDR_W),
      .LEN_W    (LEN_W)
   ) i_writer (
      .clk       (clk),
      .rst_n     (rst_n),
      .info_vld  (info_vld),
      .info_byte (info_byte),
      .frm_start (frm_start),
      .frm_end   (frm_end),
      .frm_bad   (frm_bad),
      .frm_len   (frm_len),
      .buf_we    (buf_we),
      .buf_addr  (buf_addr),
      .buf_wdata (buf_wdata),
      .eom       (eom),
      .fcs_err   (fcs_err),
      .ovfl      (ovfl),
      .msg_len   (msg_len)
   );

endmodule

// File: rtl/lapd_pmdl_rx_chk.sv
module lapd_pmdl_rx_chk #(
   parameter int BUF_BASE = 'hDE,
   parameter int BUF_LAST = 'h135,
   parameter int ADDR_W   = 9,
   parameter int LEN_W    = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_vld,
   input logic              buf_we,
   input logic [ADDR_W-1:0] buf_addr,
   input logic              eom,
   input logic              fcs_err,
   input logic              ovfl,
   input logic [LEN_W-1:0]  msg_len
);

   localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BUF_BASE);
   localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BUF_LAST);

   AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> (buf_addr >= LO_A && buf_addr <= HI_A)); // R8

   AST_WR_ONE_PER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |=> !buf_we); // R3

   AST_EOM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      eom |=> !eom); // R6

   AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !eom |-> ($stable(msg_len) && $stable(fcs_err) && $stable(ovfl))); // R4

   AST_EOM_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      eom |-> $past(bit_vld, 3)); // R10

   AST_WR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> $past(bit_vld, 3)); // R10

endmodule

bind lapd_pmdl_rx lapd_pmdl_rx_chk #(
   .BUF_BASE (BUF_BASE),
   .BUF_LAST (BUF_LAST),
   .ADDR_W   (ADDR_W),
   .LEN_W    (LEN_W)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bit_vld  (bit_vld),
   .buf_we   (buf_we),
   .buf_addr (buf_addr),
   .eom      (eom),
   .fcs_err  (fcs_err),
   .ovfl     (ovfl),
   .msg_len  (msg_len)
);

// File: tb/test_lapd_pmdl_rx.sv
module test_lapd_pmdl_rx;

   localparam int BASE  = 'hDE;
   localparam int LAST  = 'h135;
   localparam int DEPTH = LAST - BASE + 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_vld = 1'b0;
   logic       bit_in = 1'b0;
   logic       buf_we;
   logic [8:0] buf_addr;
   logic [7:0] buf_wdata;
   logic       eom;
   logic       fcs_err;
   logic       ovfl;
   logic [9:0] msg_len;

   always #2 clk = ~clk;

   lapd_pmdl_rx i_lapd_pmdl_rx (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
      .eom(eom), .fcs_err(fcs_err), .ovfl(ovfl), .msg_len(msg_len)
   );

   int n_chk = 0;
   int n_err = 0;
   int burst = 0;
   int tx_ones = 0;
   int wr_seen = 0;
   int eom_seen = 0;
   int eom_wide = 0;
   int addr_bad = 0;
   logic eom_prev = 1'b0;
   logic cap_err = 1'b0;
   logic cap_ovf = 1'b0;
   int   cap_len = 0;
   logic [7:0] mem [0:511];
   logic [7:0] tx  [0:127];

   always @(negedge clk) begin
      if (rst_n) begin
         if (buf_we) begin
            mem[buf_addr] = buf_wdata;
            wr_seen++;
            if (int'(buf_addr) < BASE || int'(buf_addr) > LAST) addr_bad++;
         end
         if (eom) begin
            eom_seen++;
            cap_err = fcs_err;
            cap_ovf = ovfl;
            cap_len = int'(msg_len);
            if (eom_prev) eom_wide++;
         end
         eom_prev = eom;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      bit_vld = 1'b1;
      bit_in  = b;
      burst++;
      if (burst == 3) begin
         burst = 0;
         @(negedge clk);
         bit_vld = 1'b0;
         bit_in  = 1'b1;
         @(negedge clk);
         bit_in  = 1'b1;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bit_vld = 1'b0;
         bit_in  = 1'b0;
      end
   endtask

   task automatic noise_gap(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bit_vld = 1'b0;
         bit_in  = 1'b1;
      end
   endtask

   task automatic send_flag();
      send_bit(1'b0);
      for (int i = 0; i < 6; i++) send_bit(1'b1);
      send_bit(1'b0);
      tx_ones = 0;
   endtask

   task automatic send_dbit(input logic b);
      send_bit(b);
      if (b) tx_ones++;
      else   tx_ones = 0;
      if (tx_ones == 5) begin
         send_bit(1'b0);
         tx_ones = 0;
      end
   endtask

   task automatic send_dbyte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) send_dbit(v[i]);
   endtask

   function automatic logic [15:0] ref_crc(input int n);
      logic [15:0] c;
      c = 16'hFFFF;
      for (int k = 0; k < n; k++)
         for (int i = 0; i < 8; i++)
            c = ((c[0] ^ tx[k][i]) != 1'b0) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
      return c;
   endfunction

   task automatic send_frame(input int n, input bit bad_fcs, input int extra, input int gap);
      logic [15:0] f;
      f = ~ref_crc(n);
      if (bad_fcs) f[0] = ~f[0];
      send_flag();
      for (int k = 0; k < n; k++) begin
         send_dbyte(tx[k]);
         if (k == 0 && gap > 0) noise_gap(gap);
      end
      send_dbyte(f[7:0]);
      send_dbyte(f[15:8]);
      for (int i = 0; i < extra; i++) send_dbit(i[0] ? 1'b0 : 1'b1);
      send_flag();
      idle(10);
   endtask

   task automatic run_good(input int n, input int gap, input string tag);
      int e0;
      int w0;
      int bad;
      int nw;
      e0 = eom_seen;
      w0 = wr_seen;
      for (int a = BASE; a <= LAST; a++) mem[a] = 8'hxx;
      send_frame(n, 1'b0, 0, gap);
      nw = (n < DEPTH) ? n : DEPTH;
      chk(eom_seen == e0 + 1, {tag, " R6 one eom"}, eom_seen - e0, 1);
      chk(cap_len == n, {tag, " R4 msg_len"}, cap_len, n);
      chk(cap_err == 1'b0, {tag, " R5 fcs ok"}, int'(cap_err), 0);
      chk(cap_ovf == (n > DEPTH), {tag, " R8 ovfl"}, int'(cap_ovf), int'(n > DEPTH));
      chk(wr_seen - w0 == nw, {tag, " R4 write count"}, wr_seen - w0, nw);
      bad = 0;
      for (int k = 0; k < nw; k++) if (mem[BASE + k] !== tx[k]) bad++;
      chk(bad == 0, {tag, " R3 R2 stored bytes"}, bad, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      int e0;
      repeat (4) @(negedge clk);
      chk(buf_we == 1'b0 && eom == 1'b0, "R11 reset strobes", int'(buf_we) + int'(eom), 0);
      chk(fcs_err == 1'b0 && ovfl == 1'b0 && msg_len == '0, "R11 reset status",
          int'(fcs_err) + int'(ovfl) + int'(msg_len), 0);
      rst_n = 1'b1;
      idle(5);

      // R1: idle flags only
      e0 = eom_seen;
      for (int i = 0; i < 4; i++) send_flag();
      idle(10);
      chk(eom_seen == e0, "R1 flags alone no eom", eom_seen - e0, 0);

      // sweep of lengths and bit patterns, with stuffing-heavy content (R2)
      for (int n = 1; n <= 12; n++) begin
         for (int p = 0; p < 3; p++) begin
            for (int k = 0; k < n; k++) begin
               case (p)
                  0: tx[k] = 8'((n * 29 + k * 53 + 7) & 255);
                  1: tx[k] = 8'hFF;
                  default: tx[k] = k[0] ? 8'hF8 : 8'h1F;
               endcase
            end
            run_good(n, 0, "sweep R1");
         end
      end

      // R10: strobe-low cycles with bit_in high must not disturb the frame
      for (int k = 0; k < 6; k++) tx[k] = 8'(k * 17 + 3);
      run_good(6, 25, "R10 gap noise");

      // R5: corrupted check sequence
      e0 = eom_seen;
      for (int k = 0; k < 5; k++) tx[k] = 8'(k + 8'h41);
      send_frame(5, 1'b1, 0, 0);
      chk(eom_seen == e0 + 1, "R5 bad fcs eom", eom_seen - e0, 1);
      chk(cap_err == 1'b1, "R5 bad fcs flagged", int'(cap_err), 1);

      // R9: bit count not a multiple of eight
      e0 = eom_seen;
      send_frame(3, 1'b0, 3, 0);
      chk(eom_seen == e0 + 1, "R9 misaligned eom", eom_seen - e0, 1);
      chk(cap_err == 1'b1, "R9 misaligned flagged", int'(cap_err), 1);

      // R9: single byte between flags
      e0 = eom_seen;
      send_flag();
      send_dbyte(8'h5A);
      send_flag();
      idle(10);
      chk(eom_seen == e0 + 1, "R9 short eom", eom_seen - e0, 1);
      chk(cap_err == 1'b1, "R9 short flagged", int'(cap_err), 1);
      chk(cap_len == 0, "R9 short length", cap_len, 0);

      // R7: abort with seven or more ones
      e0 = eom_seen;
      send_flag();
      send_dbyte(8'h12);
      send_dbyte(8'h34);
      for (int i = 0; i < 8; i++) send_bit(1'b1);
      idle(10);
      chk(eom_seen == e0, "R7 abort no eom", eom_seen - e0, 0);
      for (int k = 0; k < 4; k++) tx[k] = 8'(8'hC0 + k);
      run_good(4, 0, "R7 resync");

      // R8: overflow of the buffer window, then recovery
      for (int k = 0; k < 90; k++) tx[k] = 8'((k * 7 + 1) & 255);
      run_good(90, 0, "R8 overflow");
      chk(addr_bad == 0, "R8 no write outside window", addr_bad, 0);
      for (int k = 0; k < 5; k++) tx[k] = 8'(8'h90 + k);
      run_good(5, 0, "R8 after overflow");

      chk(eom_wide == 0, "R6 eom one cycle", eom_wide, 0);

      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule